// File: doc/BRIEF.md
# Vector/Scalar Scoreboarded Issue Stage

This block is the decode-side issue stage of a pipeline that runs scalar and vector instructions from one instruction stream. Instructions issue in order and may complete out of order. Each incoming instruction carries a class bit (scalar or vector), one destination and two source register numbers from a register space of `NREG` (32) entries. A scoreboard records, for every register, whether a write is still outstanding and how many issued instructions have not yet read it. From this it detects read-after-write, write-after-write and write-after-read conflicts. While a conflict remains, the stage holds the instruction and asserts a fetch stall.

A scalar instruction leaves in a single issue beat. A vector instruction leaves as one beat per element, on back-to-back cycles, with an element index counting up from zero. The number of beats comes from a vector-length register whose writes are clamped to the range 1 to `MAX_VL`. The execution side reports completed results on a writeback port and finished operand reads on a read-release port. Both free scoreboard state, and both take effect within the same cycle they arrive.

The state machine has two states. `ST_READY` accepts a new instruction. `ST_VECRUN` streams the remaining elements of a vector instruction. The transitions are:
- `ST_READY` to `ST_VECRUN` when a vector instruction is accepted while the latched length is greater than 1.
- `ST_VECRUN` to `ST_VECRUN` while elements remain.
- `ST_VECRUN` to `ST_READY` on the beat that carries the last element.
- `ST_READY` to `ST_READY` in every other case.

Top module: `vsis_issue`

## Requirements
- R1: An instruction is held (no issue, `fetch_stall` high) while either of its source registers has an outstanding write (read-after-write).
- R2: An instruction is held while its destination register has an outstanding write (write-after-write).
- R3: An instruction is held while its destination has a non-zero pending-read count. That count rises by one for each source field that names the register when an instruction is accepted, and falls by one for each field of a read-release beat that names it.
- R4: In `ST_READY`, `fetch_stall` equals `in_valid` and not accepted. In `ST_VECRUN`, `fetch_stall` is high regardless of the input.
- R5: An accepted instruction issues combinationally in the same cycle with `issue_elem` = 0. A scalar instruction issues exactly once, and a non-conflicting instruction presented on the next cycle is accepted on that cycle.
- R6: A vector instruction accepted with length L issues L beats on consecutive cycles, with `issue_elem` running 0 to L-1 and the destination held constant. No new instruction is accepted before the last beat.
- R7: After reset the vector length reads `MAX_VL`. A write above `MAX_VL` stores `MAX_VL`, a write of 0 stores 1, and other values are stored unchanged. The written value is visible after the next clock edge.
- R8: Scoreboard state is recorded when an instruction is accepted (its first beat). The destination's outstanding write clears only on a writeback beat naming it.
- R9: A writeback or read-release arriving in the same cycle as an instruction whose conflict it removes lets that instruction issue in that cycle.
- R10: An instruction is held while a source register's pending-read count exceeds the counter maximum minus 2. With the default 3-bit counter, the count may therefore not exceed 5 when the instruction is accepted.
- R11: During and right after reset, nothing issues, `fetch_stall` is low without a valid input, and no register has scoreboard state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_vec | input | 1 | 1 = vector class, 0 = scalar |
| in_dst | input | RW | Destination register |
| in_src_a | input | RW | First source register |
| in_src_b | input | RW | Second source register |
| vl_we | input | 1 | Vector-length write strobe |
| vl_wdata | input | LW | Requested vector length |
| wb_valid | input | 1 | Result writeback beat |
| wb_reg | input | RW | Register written back |
| rel_valid | input | 1 | Operand-read release beat |
| rel_a | input | RW | First released source |
| rel_b | input | RW | Second released source |
| issue_valid | output | 1 | Issue beat to execution |
| issue_vec | output | 1 | Class of the issued instruction |
| issue_dst | output | RW | Issued destination |
| issue_src_a | output | RW | Issued first source |
| issue_src_b | output | RW | Issued second source |
| issue_elem | output | EW | Element index of this beat |
| fetch_stall | output | 1 | Hold instruction fetch |
| vl_len | output | LW | Current vector length |

## Verification
The bench targets the three conflict kinds both one at a time and resolved by a writeback or release in the same cycle. A design without that bypass would lose a cycle, and one that drops the write-after-read check would let a write overtake an earlier reader. It streams a three-element vector while a second instruction waits: a design that counts elements wrongly would issue too many or too few beats, and one that accepts early would change the destination in mid-stream. It also checks vector-length clamping at both ends, and it fills a pending-read counter until the stage must hold rather than wrap the count to zero.

// File: rtl/vsis_pkg.sv
package vsis_pkg;
    typedef enum logic {
        ST_READY  = 1'b0,
        ST_VECRUN = 1'b1
    } iss_state_t;
endpackage

// File: rtl/vsis_scoreboard.sv
module vsis_scoreboard #(
    parameter int NREG = 32,
    parameter int RW   = 5,
    parameter int CW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [RW-1:0] set_dst,
    input  logic [RW-1:0] set_a,
    input  logic [RW-1:0] set_b,
    input  logic          wb_en,
    input  logic [RW-1:0] wb_reg,
    input  logic          rel_en,
    input  logic [RW-1:0] rel_a,
    input  logic [RW-1:0] rel_b,
    input  logic [RW-1:0] q_dst,
    input  logic [RW-1:0] q_a,
    input  logic [RW-1:0] q_b,
    output logic          raw_haz,
    output logic          waw_haz,
    output logic          war_haz,
    output logic          cnt_full
);
    localparam int CMAX = (1 << CW) - 1;

    logic [NREG-1:0] pend_eff;
    logic [CW-1:0]   cnt_eff [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic          pq;
        logic [CW-1:0] cq;
        logic [1:0]    dec;
        logic [1:0]    inc;

        assign dec = {1'b0, rel_en && (rel_a == RW'(g))} + {1'b0, rel_en && (rel_b == RW'(g))};
        assign inc = {1'b0, set_en && (set_a == RW'(g))} + {1'b0, set_en && (set_b == RW'(g))};
        assign pend_eff[g] = pq & ~(wb_en && (wb_reg == RW'(g)));
        assign cnt_eff[g]  = (cq > CW'(dec)) ? cq - CW'(dec) : '0;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pq <= 1'b0;
                cq <= '0;
            end else begin
                pq <= pend_eff[g] | (set_en && (set_dst == RW'(g)));
                cq <= cnt_eff[g] + CW'(inc);
            end
        end
    end

    always_comb begin
        raw_haz  = pend_eff[q_a] | pend_eff[q_b];
        waw_haz  = pend_eff[q_dst];
        war_haz  = (cnt_eff[q_dst] != '0);
        cnt_full = (int'(cnt_eff[q_a]) > CMAX - 2) || (int'(cnt_eff[q_b]) > CMAX - 2);
    end
endmodule

// File: rtl/vsis_vlen.sv
module vsis_vlen #(
    parameter int MAX_VL = 8,
    parameter int LW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [LW-1:0] wdata,
    output logic [LW-1:0] len
);
    logic [LW-1:0] len_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            len_q <= LW'(MAX_VL);
        else if (we) begin
            if (int'(wdata) > MAX_VL) len_q <= LW'(MAX_VL);
            else if (wdata == '0)     len_q <= LW'(1);
            else                      len_q <= wdata;
        end
    end

    assign len = len_q;
endmodule

// File: rtl/vsis_issue.sv
module vsis_issue #(
    parameter int NREG   = 32,
    parameter int MAX_VL = 8,
    parameter int RCNT_W = 3,
    parameter int RW     = $clog2(NREG),
    parameter int LW     = $clog2(MAX_VL + 1),
    parameter int EW     = $clog2(MAX_VL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_vec,
    input  logic [RW-1:0] in_dst,
    input  logic [RW-1:0] in_src_a,
    input  logic [RW-1:0] in_src_b,
    input  logic          vl_we,
    input  logic [LW-1:0] vl_wdata,
    input  logic          wb_valid,
    input  logic [RW-1:0] wb_reg,
    input  logic          rel_valid,
    input  logic [RW-1:0] rel_a,
    input  logic [RW-1:0] rel_b,
    output logic          issue_valid,
    output logic          issue_vec,
    output logic [RW-1:0] issue_dst,
    output logic [RW-1:0] issue_src_a,
    output logic [RW-1:0] issue_src_b,
    output logic [EW-1:0] issue_elem,
    output logic          fetch_stall,
    output logic [LW-1:0] vl_len
);
    import vsis_pkg::*;

    iss_state_t    state_q, state_d;
    logic          raw_h, waw_h, war_h, full_h, hazard, accept;
    logic [RW-1:0] hold_dst, hold_a, hold_b;
    logic [EW-1:0] elem_q;
    logic [LW-1:0] len_q;
    logic          last_beat;

    vsis_scoreboard #(.NREG(NREG), .RW(RW), .CW(RCNT_W)) u_sb (
        .clk(clk), .rst_n(rst_n),
        .set_en(accept), .set_dst(in_dst), .set_a(in_src_a), .set_b(in_src_b),
        .wb_en(wb_valid), .wb_reg(wb_reg),
        .rel_en(rel_valid), .rel_a(rel_a), .rel_b(rel_b),
        .q_dst(in_dst), .q_a(in_src_a), .q_b(in_src_b),
        .raw_haz(raw_h), .waw_haz(waw_h), .war_haz(war_h), .cnt_full(full_h)
    );

    vsis_vlen #(.MAX_VL(MAX_VL), .LW(LW)) u_vl (
        .clk(clk), .rst_n(rst_n), .we(vl_we), .wdata(vl_wdata), .len(vl_len)
    );

    assign hazard    = raw_h | waw_h | war_h | full_h;
    assign accept    = (state_q == ST_READY) && in_valid && !hazard;
    assign last_beat = (elem_q == EW'(len_q - LW'(1)));

    // state register and datapath hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_READY;
            elem_q   <= '0;
            len_q    <= '0;
            hold_dst <= '0;
            hold_a   <= '0;
            hold_b   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                hold_dst <= in_dst;
                hold_a   <= in_src_a;
                hold_b   <= in_src_b;
                len_q    <= vl_len;
                elem_q   <= EW'(1);
            end else if (state_q == ST_VECRUN) begin
                elem_q <= elem_q + EW'(1);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY:  if (accept && in_vec && (vl_len > LW'(1))) state_d = ST_VECRUN;
            ST_VECRUN: if (last_beat) state_d = ST_READY;
            default:   state_d = ST_READY;
        endcase
    end

    // outputs
    always_comb begin
        issue_valid = 1'b0;
        issue_vec   = 1'b0;
        issue_dst   = in_dst;
        issue_src_a = in_src_a;
        issue_src_b = in_src_b;
        issue_elem  = '0;
        fetch_stall = 1'b0;
        unique case (state_q)
            ST_READY: begin
                issue_valid = accept;
                issue_vec   = in_vec;
                fetch_stall = in_valid && !accept;
            end
            ST_VECRUN: begin
                issue_valid = 1'b1;
                issue_vec   = 1'b1;
                issue_dst   = hold_dst;
                issue_src_a = hold_a;
                issue_src_b = hold_b;
                issue_elem  = elem_q;
                fetch_stall = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vsis_issue_chk.sv
module vsis_issue_chk #(
    parameter int MAX_VL = 8,
    parameter int RW     = 5,
    parameter int LW     = 4,
    parameter int EW     = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          issue_valid,
    input logic          issue_vec,
    input logic [RW-1:0] issue_dst,
    input logic [EW-1:0] issue_elem,
    input logic          fetch_stall,
    input logic [LW-1:0] vl_len
);
    // R7
    vl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vl_len >= LW'(1)) && (int'(vl_len) <= MAX_VL));

    // R6
    elem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_elem != '0) |->
            ($past(issue_valid) && issue_elem == $past(issue_elem) + EW'(1)));

    // R6
    elem_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_elem != '0) |-> $stable(issue_dst));

    // R4
    run_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_elem != '0) |-> fetch_stall);

    // R5
    scalar_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !issue_vec) |=> (issue_elem == '0));
endmodule

bind vsis_issue vsis_issue_chk #(.MAX_VL(MAX_VL), .RW(RW), .LW(LW), .EW(EW)) u_chk (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_vec(issue_vec),
    .issue_dst(issue_dst), .issue_elem(issue_elem), .fetch_stall(fetch_stall),
    .vl_len(vl_len)
);

// File: tb/vsis_issue_test.sv
module vsis_issue_test;
    localparam int PERIOD = 10;
    localparam int RW = 5, LW = 4, EW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, in_vec = 0;
    logic [RW-1:0] in_dst = 0, in_src_a = 0, in_src_b = 0;
    logic vl_we = 0;
    logic [LW-1:0] vl_wdata = 0;
    logic wb_valid = 0, rel_valid = 0;
    logic [RW-1:0] wb_reg = 0, rel_a = 0, rel_b = 0;
    logic issue_valid, issue_vec, fetch_stall;
    logic [RW-1:0] issue_dst, issue_src_a, issue_src_b;
    logic [EW-1:0] issue_elem;
    logic [LW-1:0] vl_len;

    int errors = 0;
    int checks = 0;

    always #(PERIOD/2) clk = ~clk;

    vsis_issue uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .vl_we(vl_we), .vl_wdata(vl_wdata), .wb_valid(wb_valid), .wb_reg(wb_reg),
        .rel_valid(rel_valid), .rel_a(rel_a), .rel_b(rel_b),
        .issue_valid(issue_valid), .issue_vec(issue_vec), .issue_dst(issue_dst),
        .issue_src_a(issue_src_a), .issue_src_b(issue_src_b), .issue_elem(issue_elem),
        .fetch_stall(fetch_stall), .vl_len(vl_len)
    );

    typedef struct packed {
        logic          v;
        logic [RW-1:0] d, a, b;
        logic          wbv;
        logic [RW-1:0] wbr;
        logic          rlv;
        logic [RW-1:0] rla, rlb;
        logic          exp_iss;
    } row_t;

    localparam row_t TBL [13] = '{
        '{1'b1, 5'd1, 5'd2,  5'd3,  1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b1}, // R5 free issue
        '{1'b1, 5'd4, 5'd1,  5'd5,  1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0}, // R1 raw on 1
        '{1'b1, 5'd1, 5'd6,  5'd7,  1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0}, // R2 waw on 1
        '{1'b1, 5'd2, 5'd8,  5'd9,  1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0}, // R3 war on 2
        '{1'b1, 5'd4, 5'd1,  5'd5,  1'b1, 5'd1, 1'b0, 5'd0, 5'd0, 1'b1}, // R9 wb bypass
        '{1'b1, 5'd3, 5'd10, 5'd11, 1'b0, 5'd0, 1'b1, 5'd2, 5'd3, 1'b1}, // R9 release bypass
        '{1'b1, 5'd2, 5'd3,  5'd12, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0}, // R8 raw on 3 set at issue
        '{1'b1, 5'd2, 5'd12, 5'd13, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b1}, // R3 count back to 0
        '{1'b0, 5'd0, 5'd0,  5'd0,  1'b1, 5'd4, 1'b0, 5'd0, 5'd0, 1'b0}, // R8 wb clears 4
        '{1'b1, 5'd6, 5'd4,  5'd4,  1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b1}, // R8 4 free
        '{1'b1, 5'd4, 5'd0,  5'd0,  1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0}, // R3 count 2 on 4
        '{1'b0, 5'd0, 5'd0,  5'd0,  1'b0, 5'd0, 1'b1, 5'd4, 5'd4, 1'b0}, // R3 release both
        '{1'b1, 5'd4, 5'd0,  5'd0,  1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b1}  // R3 count now 0
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic vec, input int d, input int a, input int b);
        @(negedge clk);
        in_valid = v; in_vec = vec;
        in_dst = RW'(d); in_src_a = RW'(a); in_src_b = RW'(b);
        wb_valid = 0; rel_valid = 0; vl_we = 0;
        #1;
    endtask

    task automatic write_vl(input int val);
        @(negedge clk);
        in_valid = 0; wb_valid = 0; rel_valid = 0;
        vl_we = 1; vl_wdata = LW'(val);
        @(negedge clk);
        vl_we = 0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk(!issue_valid, "R11 issue in reset", issue_valid, 0);
        chk(!fetch_stall, "R11 stall in reset", fetch_stall, 0);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R7 reset length
        chk(vl_len == LW'(8), "R7 vl after reset", vl_len, 8);

        // table walk
        foreach (TBL[i]) begin
            @(negedge clk);
            in_valid = TBL[i].v; in_vec = 0;
            in_dst = TBL[i].d; in_src_a = TBL[i].a; in_src_b = TBL[i].b;
            wb_valid = TBL[i].wbv; wb_reg = TBL[i].wbr;
            rel_valid = TBL[i].rlv; rel_a = TBL[i].rla; rel_b = TBL[i].rlb;
            #1;
            chk(issue_valid == TBL[i].exp_iss, $sformatf("R1/R2/R3 table row %0d issue", i),
                issue_valid, TBL[i].exp_iss);
            // R4 stall mirrors a held valid input
            chk(fetch_stall == (TBL[i].v && !TBL[i].exp_iss),
                $sformatf("R4 table row %0d stall", i), fetch_stall, TBL[i].v && !TBL[i].exp_iss);
            if (TBL[i].exp_iss)
                chk(issue_dst == TBL[i].d && issue_elem == 0,
                    $sformatf("R5 table row %0d dst", i), issue_dst, TBL[i].d);
        end

        // R7 length write and vector streaming (R6)
        write_vl(3);
        chk(vl_len == LW'(3), "R7 vl write 3", vl_len, 3);
        drive(1, 1, 20, 21, 22);
        chk(issue_valid && issue_elem == 0 && !fetch_stall, "R6 vec beat 0", issue_elem, 0);
        drive(1, 0, 23, 24, 25);
        chk(issue_valid && issue_elem == 1 && issue_dst == 20, "R6 vec beat 1", issue_dst, 20);
        chk(fetch_stall, "R4 stall during run", fetch_stall, 1);
        drive(1, 0, 23, 24, 25);
        chk(issue_valid && issue_elem == 2 && issue_dst == 20, "R6 vec beat 2", issue_elem, 2);
        drive(1, 0, 23, 24, 25);
        chk(issue_valid && issue_elem == 0 && issue_dst == 23 && !fetch_stall,
            "R6 waiting scalar after last beat", issue_dst, 23);
        // R2 vector waits on outstanding write to 20
        drive(1, 1, 20, 0, 0);
        chk(!issue_valid && fetch_stall, "R2 vector waw hold", issue_valid, 0);
        drive(0, 0, 0, 0, 0);

        // R7 clamps
        write_vl(12);
        chk(vl_len == LW'(8), "R7 clamp high", vl_len, 8);
        write_vl(0);
        chk(vl_len == LW'(1), "R7 clamp zero", vl_len, 1);
        // R5 length-1 vector then back-to-back scalar
        drive(1, 1, 15, 16, 17);
        chk(issue_valid && issue_elem == 0, "R6 length one beat", issue_valid, 1);
        drive(1, 0, 18, 19, 19);
        chk(issue_valid && issue_dst == 18 && issue_elem == 0, "R5 next cycle accept", issue_dst, 18);

        // R10 counter saturation on register 30
        drive(1, 0, 26, 30, 30);
        chk(issue_valid, "R10 reader 1", issue_valid, 1);
        drive(1, 0, 27, 30, 30);
        chk(issue_valid, "R10 reader 2", issue_valid, 1);
        drive(1, 0, 28, 30, 30);
        chk(issue_valid, "R10 reader 3", issue_valid, 1);
        drive(1, 0, 29, 30, 30);
        chk(!issue_valid && fetch_stall, "R10 full counter hold", issue_valid, 0);
        drive(0, 0, 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule